// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache

This block keeps recently used virtual-to-physical page translations for a paged memory system whose address spaces carry identifiers (ASIDs). It has 64 slots and no associativity. The slot for a virtual address comes from the six address bits just above the 4 KiB page offset. A lookup reads only that slot and registers a response one cycle later. The response holds hit or miss, the slot number and every stored field, so the page-table walker and permission logic around the block can use the cached page-table entry without walking again.

Translations enter through a shared entry bus. A fill command places the entry in the slot that its own virtual address selects. A write command places the same kind of entry in a slot named by an explicit index, which lets a caller rewrite the slot that just hit. The entry's page-table level sets the size of the page. The block derives a match mask from the level, and both stored addresses keep only the bits above the page offset. A large page is cached one 4 KiB region at a time, so each region that is filled gets its own slot. A flush command tests every slot in one cycle against an optional ASID filter and an optional address filter. A synchronous reset empties the whole buffer.

Top module: `xlate_cache`

## Requirements
- R1: While `rst` is high at a clock edge, every slot becomes invalid. Any lookup after reset reports a miss until an entry is installed.
- R2: A lookup presented with `lk_valid` at one edge is answered after that edge with `rsp_valid`=1. The slot read is `lk_vaddr[17:12]`, and `rsp_index` carries that value on a hit.
- R3: A hit requires three things: the indexed slot is valid, `lk_vaddr` ANDed with the stored match mask equals the stored virtual address, and either the stored global flag is 1 or the stored ASID equals `lk_asid`. Any other case is a miss.
- R4: An installed entry uses a shift of 12 + 9 × `ent_level`. The match mask has bits [63:shift] set and the offset mask is its complement. The stored virtual and physical addresses are the entry addresses ANDed with the match mask. ASID, global flag, PTE, PTE address and `ent_stamp` are stored unchanged, and all of them are returned on a hit.
- R5: A fill writes only the slot given by `ent_vaddr[17:12]`, whatever the page level. Another 4 KiB region of the same large page misses until that region is filled as well.
- R6: A fill into an occupied slot replaces the old entry, which then misses.
- R7: `wr_en` installs the entry bus contents into slot `wr_index`, regardless of the index bits of `ent_vaddr`.
- R8: A flush with `fl_use_asid`=0 and `fl_use_addr`=0 invalidates every slot.
- R9: A flush with only `fl_use_addr`=1 invalidates each valid slot whose stored virtual address equals `fl_vaddr` ANDed with that slot's match mask. Global and ASID do not matter.
- R10: A flush with only `fl_use_asid`=1 invalidates each valid non-global slot whose ASID equals `fl_asid`. Global slots survive.
- R11: A flush with both filters set invalidates only non-global slots that pass both the ASID test and the address test.
- R12: A lookup at an edge sees the contents from before that edge. When a fill or write shares an edge with a flush, the new entry is applied after the flush and survives it. When fill and write share an edge, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties all slots |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_vaddr | input | 64 | Lookup virtual address |
| ent_asid | input | 16 | Entry bus: ASID |
| ent_global | input | 1 | Entry bus: global flag |
| ent_level | input | 2 | Entry bus: page-table level (0 = 4 KiB) |
| ent_vaddr | input | 64 | Entry bus: virtual address |
| ent_paddr | input | 64 | Entry bus: physical address |
| ent_pte | input | 64 | Entry bus: opaque page-table entry |
| ent_pte_addr | input | 64 | Entry bus: address of the page-table entry |
| ent_stamp | input | 64 | Entry bus: age stamp (cycle count) |
| fill_en | input | 1 | Install entry into the slot its vaddr selects |
| wr_en | input | 1 | Install entry into slot `wr_index` |
| wr_index | input | 6 | Target slot for `wr_en` |
| fl_en | input | 1 | Flush request |
| fl_use_asid | input | 1 | Flush filter: match on ASID |
| fl_use_addr | input | 1 | Flush filter: match on address |
| fl_asid | input | 16 | Flush ASID |
| fl_vaddr | input | 64 | Flush virtual address |
| rsp_valid | output | 1 | Registered response for the previous lookup |
| rsp_hit | output | 1 | Response is a hit |
| rsp_index | output | 6 | Slot that was read |
| rsp_asid | output | 16 | Stored ASID |
| rsp_global | output | 1 | Stored global flag |
| rsp_pte | output | 64 | Stored PTE |
| rsp_pte_addr | output | 64 | Stored PTE address |
| rsp_match_mask | output | 64 | Stored match mask |
| rsp_offset_mask | output | 64 | Complement of the match mask |
| rsp_vaddr | output | 64 | Stored masked virtual address |
| rsp_paddr | output | 64 | Stored masked physical address |
| rsp_age | output | 64 | Stored age stamp |

## Verification
Some properties are checked on every cycle. A hit is always consistent with the lookup that produced it, in both the address under the mask and the ASID or global rule. Returned addresses never carry bits below the mask. A reset or an unfiltered flush leaves no slot valid, and a fill always leaves its target slot valid. Other behaviour shows only in the bench's scenarios, which compare against a reference model. These cover which slots each filter kind removes and that global entries survive ASID flushes. They also cover the copy-per-region behaviour of large pages, replacement on index conflicts, writes by explicit index, and the ordering of lookup, flush and install on the same edge.

// File: rtl/xc_pkg.sv
package xc_pkg;

  // Flush filter kind, formed as {use_asid, use_addr}
  typedef enum logic [1:0] {
    FLUSH_ALL  = 2'b00,
    FLUSH_ADDR = 2'b01,
    FLUSH_ASID = 2'b10,
    FLUSH_BOTH = 2'b11
  } flush_kind_e;

endpackage

// File: rtl/xc_fill_prep.sv
module xc_fill_prep #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned LEVEL_W     = 2,
  parameter int unsigned OFFSET_BITS = 12,
  parameter int unsigned LEVEL_BITS  = 9
) (
  input  logic [LEVEL_W-1:0] level,
  input  logic [ADDR_W-1:0]  vaddr,
  input  logic [ADDR_W-1:0]  paddr,
  output logic [ADDR_W-1:0]  match_mask,
  output logic [ADDR_W-1:0]  vaddr_m,
  output logic [ADDR_W-1:0]  paddr_m
);

  int unsigned sh;
  logic [ADDR_W-1:0] off_mask;

  always_comb begin
    sh = OFFSET_BITS + int'(level) * LEVEL_BITS;
    if (sh >= ADDR_W) off_mask = '1;
    else              off_mask = (ADDR_W'(1) << sh) - ADDR_W'(1);
  end

  assign match_mask = ~off_mask;
  assign vaddr_m    = vaddr & match_mask;
  assign paddr_m    = paddr & match_mask;

endmodule

// File: rtl/xc_tag_cmp.sv
module xc_tag_cmp #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ASID_W = 16
) (
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] st_va,
  input  logic [ASID_W-1:0] st_asid,
  input  logic [ADDR_W-1:0] probe_va,
  input  logic [ASID_W-1:0] probe_asid,
  output logic              addr_eq,
  output logic              asid_eq
);

  assign addr_eq = ((probe_va & mask) == st_va);
  assign asid_eq = (probe_asid == st_asid);

endmodule

// File: rtl/xc_flush_slot.sv
module xc_flush_slot import xc_pkg::*; #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned ASID_W = 16
) (
  input  logic              valid,
  input  logic              glob,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] st_va,
  input  logic [ASID_W-1:0] st_asid,
  input  flush_kind_e       kind,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [ADDR_W-1:0] fl_vaddr,
  output logic              kill
);

  logic a_eq, s_eq;

  xc_tag_cmp #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_cmp (
    .mask(mask), .st_va(st_va), .st_asid(st_asid),
    .probe_va(fl_vaddr), .probe_asid(fl_asid),
    .addr_eq(a_eq), .asid_eq(s_eq)
  );

  always_comb begin
    unique case (kind)
      FLUSH_ALL:  kill = valid;
      FLUSH_ADDR: kill = valid & a_eq;
      FLUSH_ASID: kill = valid & ~glob & s_eq;
      default:    kill = valid & ~glob & s_eq & a_eq;
    endcase
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache import xc_pkg::*; #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned ASID_W      = 16,
  parameter int unsigned PTE_W       = 64,
  parameter int unsigned AGE_W       = 64,
  parameter int unsigned NUM_SLOTS   = 64,
  parameter int unsigned OFFSET_BITS = 12,
  parameter int unsigned LEVEL_BITS  = 9,
  parameter int unsigned LEVEL_W     = 2,
  localparam int unsigned IDX_W      = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [ADDR_W-1:0] lk_vaddr,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_global,
  input  logic [LEVEL_W-1:0] ent_level,
  input  logic [ADDR_W-1:0] ent_vaddr,
  input  logic [ADDR_W-1:0] ent_paddr,
  input  logic [PTE_W-1:0]  ent_pte,
  input  logic [ADDR_W-1:0] ent_pte_addr,
  input  logic [AGE_W-1:0]  ent_stamp,
  input  logic              fill_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic              fl_en,
  input  logic              fl_use_asid,
  input  logic              fl_use_addr,
  input  logic [ASID_W-1:0] fl_asid,
  input  logic [ADDR_W-1:0] fl_vaddr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_index,
  output logic [ASID_W-1:0] rsp_asid,
  output logic              rsp_global,
  output logic [PTE_W-1:0]  rsp_pte,
  output logic [ADDR_W-1:0] rsp_pte_addr,
  output logic [ADDR_W-1:0] rsp_match_mask,
  output logic [ADDR_W-1:0] rsp_offset_mask,
  output logic [ADDR_W-1:0] rsp_vaddr,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [AGE_W-1:0]  rsp_age
);

  // Slot storage: valid bits resettable, payload arrays single-write-port
  logic [NUM_SLOTS-1:0] vld, kill;
  logic [ASID_W-1:0] st_asid [NUM_SLOTS];
  logic              st_glob [NUM_SLOTS];
  logic [PTE_W-1:0]  st_pte  [NUM_SLOTS];
  logic [ADDR_W-1:0] st_pta  [NUM_SLOTS];
  logic [ADDR_W-1:0] st_mm   [NUM_SLOTS];
  logic [ADDR_W-1:0] st_va   [NUM_SLOTS];
  logic [ADDR_W-1:0] st_pa   [NUM_SLOTS];
  logic [AGE_W-1:0]  st_age  [NUM_SLOTS];

  // Install path: fill selects by address hash, write by explicit index
  logic [ADDR_W-1:0] new_mm, new_va, new_pa;
  logic              we;
  logic [IDX_W-1:0]  wsel;

  xc_fill_prep #(
    .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W),
    .OFFSET_BITS(OFFSET_BITS), .LEVEL_BITS(LEVEL_BITS)
  ) u_prep (
    .level(ent_level), .vaddr(ent_vaddr), .paddr(ent_paddr),
    .match_mask(new_mm), .vaddr_m(new_va), .paddr_m(new_pa)
  );

  assign we   = fill_en | wr_en;
  assign wsel = fill_en ? ent_vaddr[OFFSET_BITS +: IDX_W] : wr_index;

  always_ff @(posedge clk) begin
    if (we) begin
      st_asid[wsel] <= ent_asid;
      st_glob[wsel] <= ent_global;
      st_pte[wsel]  <= ent_pte;
      st_pta[wsel]  <= ent_pte_addr;
      st_mm[wsel]   <= new_mm;
      st_va[wsel]   <= new_va;
      st_pa[wsel]   <= new_pa;
      st_age[wsel]  <= ent_stamp;
    end
  end

  // Flush: every slot evaluated in parallel
  flush_kind_e fl_kind;
  assign fl_kind = flush_kind_e'({fl_use_asid, fl_use_addr});

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    xc_flush_slot #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_fl (
      .valid(vld[s]), .glob(st_glob[s]), .mask(st_mm[s]),
      .st_va(st_va[s]), .st_asid(st_asid[s]), .kind(fl_kind),
      .fl_asid(fl_asid), .fl_vaddr(fl_vaddr), .kill(kill[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (fl_en) vld <= vld & ~kill;
      if (we)    vld[wsel] <= 1'b1;
    end
  end

  // Lookup: read indexed slot, compare, register
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_addr_eq, lk_asid_eq, lk_hit;

  assign lk_idx = lk_vaddr[OFFSET_BITS +: IDX_W];

  xc_tag_cmp #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_lk (
    .mask(st_mm[lk_idx]), .st_va(st_va[lk_idx]), .st_asid(st_asid[lk_idx]),
    .probe_va(lk_vaddr), .probe_asid(lk_asid),
    .addr_eq(lk_addr_eq), .asid_eq(lk_asid_eq)
  );

  assign lk_hit = vld[lk_idx] & lk_addr_eq & (st_glob[lk_idx] | lk_asid_eq);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid & lk_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_valid) begin
      rsp_index      <= lk_idx;
      rsp_asid       <= st_asid[lk_idx];
      rsp_global     <= st_glob[lk_idx];
      rsp_pte        <= st_pte[lk_idx];
      rsp_pte_addr   <= st_pta[lk_idx];
      rsp_match_mask <= st_mm[lk_idx];
      rsp_vaddr      <= st_va[lk_idx];
      rsp_paddr      <= st_pa[lk_idx];
      rsp_age        <= st_age[lk_idx];
    end
  end

  assign rsp_offset_mask = ~rsp_match_mask;

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (vld == '0));

  // R2
  hit_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  // R3
  hit_tag_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> ((($past(lk_vaddr) & rsp_match_mask) == rsp_vaddr) &&
                 (rsp_global || (rsp_asid == $past(lk_asid)))));

  // R4
  masked_store_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (((rsp_paddr & rsp_offset_mask) == '0) &&
                 ((rsp_vaddr & rsp_offset_mask) == '0)));

  // R5
  fill_slot_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fill_en) && !$past(rst)) |->
      vld[$past(ent_vaddr[OFFSET_BITS +: IDX_W])]);

  // R8
  flush_all_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fl_en && !fl_use_asid && !fl_use_addr && !fill_en && !wr_en))
      |-> (vld == '0));

endmodule

// File: tb/test_xlate_cache.sv
module test_xlate_cache;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [15:0] lk_asid;
  logic [63:0] lk_vaddr;
  logic [15:0] ent_asid;
  logic        ent_global;
  logic [1:0]  ent_level;
  logic [63:0] ent_vaddr, ent_paddr, ent_pte, ent_pte_addr, ent_stamp;
  logic        fill_en, wr_en;
  logic [5:0]  wr_index;
  logic        fl_en, fl_use_asid, fl_use_addr;
  logic [15:0] fl_asid;
  logic [63:0] fl_vaddr;
  logic        rsp_valid, rsp_hit, rsp_global;
  logic [5:0]  rsp_index;
  logic [15:0] rsp_asid;
  logic [63:0] rsp_pte, rsp_pte_addr, rsp_match_mask, rsp_offset_mask;
  logic [63:0] rsp_vaddr, rsp_paddr, rsp_age;

  xlate_cache i_xlate_cache (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
    .ent_asid(ent_asid), .ent_global(ent_global), .ent_level(ent_level),
    .ent_vaddr(ent_vaddr), .ent_paddr(ent_paddr), .ent_pte(ent_pte),
    .ent_pte_addr(ent_pte_addr), .ent_stamp(ent_stamp),
    .fill_en(fill_en), .wr_en(wr_en), .wr_index(wr_index),
    .fl_en(fl_en), .fl_use_asid(fl_use_asid), .fl_use_addr(fl_use_addr),
    .fl_asid(fl_asid), .fl_vaddr(fl_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_index(rsp_index),
    .rsp_asid(rsp_asid), .rsp_global(rsp_global), .rsp_pte(rsp_pte),
    .rsp_pte_addr(rsp_pte_addr), .rsp_match_mask(rsp_match_mask),
    .rsp_offset_mask(rsp_offset_mask), .rsp_vaddr(rsp_vaddr),
    .rsp_paddr(rsp_paddr), .rsp_age(rsp_age)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  longint unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference model
  bit          m_v   [64];
  logic [15:0] m_asid[64];
  bit          m_g   [64];
  logic [63:0] m_pte [64], m_pta[64], m_mm[64], m_va[64], m_pa[64], m_age[64];

  function automatic logic [63:0] mask_of(input logic [1:0] lvl);
    int sh = 12 + 9 * int'(lvl);
    return ~((64'd1 << sh) - 64'd1);
  endfunction

  function automatic bit model_hit(input logic [15:0] a, input logic [63:0] va);
    int ix = int'(va[17:12]);
    return m_v[ix] && ((va & m_mm[ix]) == m_va[ix]) && (m_g[ix] || m_asid[ix] == a);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    lk_valid = 0; fill_en = 0; wr_en = 0; fl_en = 0;
    fl_use_asid = 0; fl_use_addr = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 64; i++) m_v[i] = 0;
  endtask

  // One clock: capture expected lookup, step, update model, check
  task automatic tick(input string tag);
    bit do_lk = lk_valid;
    int ix = int'(lk_vaddr[17:12]);
    bit e_hit = model_hit(lk_asid, lk_vaddr);
    logic [63:0] e_pa = m_pa[ix], e_va = m_va[ix], e_mm = m_mm[ix];
    logic [63:0] e_pte = m_pte[ix], e_pta = m_pta[ix], e_age = m_age[ix];
    logic [15:0] e_asid = m_asid[ix];
    bit e_g = m_g[ix];
    int w;
    @(posedge clk); #1;
    if (rst) model_reset();
    else begin
      if (fl_en) begin
        for (int i = 0; i < 64; i++) begin
          bit a_ok = ((fl_vaddr & m_mm[i]) == m_va[i]);
          bit s_ok = (m_asid[i] == fl_asid) && !m_g[i];
          bit k;
          case ({fl_use_asid, fl_use_addr})
            2'b00: k = 1;
            2'b01: k = a_ok;
            2'b10: k = s_ok;
            default: k = s_ok && a_ok;
          endcase
          if (m_v[i] && k) m_v[i] = 0;
        end
      end
      if (fill_en || wr_en) begin
        w = fill_en ? int'(ent_vaddr[17:12]) : int'(wr_index);
        m_v[w] = 1; m_asid[w] = ent_asid; m_g[w] = ent_global;
        m_pte[w] = ent_pte; m_pta[w] = ent_pte_addr; m_mm[w] = mask_of(ent_level);
        m_va[w] = ent_vaddr & mask_of(ent_level); m_pa[w] = ent_paddr & mask_of(ent_level);
        m_age[w] = ent_stamp;
      end
    end
    clear_inputs();
    if (do_lk) begin
      chk({tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
      chk({tag, " hit"}, 64'(rsp_hit), 64'(e_hit));
      if (e_hit && rsp_hit) begin
        chk({tag, " R2 index"}, 64'(rsp_index), 64'(ix));
        chk({tag, " R4 paddr"}, rsp_paddr, e_pa);
        chk({tag, " R4 vaddr"}, rsp_vaddr, e_va);
        chk({tag, " R4 mask"}, rsp_match_mask, e_mm);
        chk({tag, " R4 offmask"}, rsp_offset_mask, ~e_mm);
        chk({tag, " R4 pte"}, rsp_pte, e_pte);
        chk({tag, " R4 pteaddr"}, rsp_pte_addr, e_pta);
        chk({tag, " R4 age"}, rsp_age, e_age);
        chk({tag, " R4 asid"}, 64'(rsp_asid), 64'(e_asid));
        chk({tag, " R4 global"}, 64'(rsp_global), 64'(e_g));
      end
    end
  endtask

  task automatic set_ent(input logic [15:0] a, input bit g, input logic [1:0] lvl,
                         input logic [63:0] va, input logic [63:0] pa);
    ent_asid = a; ent_global = g; ent_level = lvl; ent_vaddr = va; ent_paddr = pa;
    ent_pte = {va[31:0], pa[31:0]} ^ 64'h5a5a; ent_pte_addr = pa ^ 64'hf00d_0000;
    ent_stamp = 64'(cyc);
  endtask

  task automatic do_fill(input logic [15:0] a, input bit g, input logic [1:0] lvl,
                         input logic [63:0] va, input logic [63:0] pa);
    set_ent(a, g, lvl, va, pa); fill_en = 1; tick("fill");
  endtask

  task automatic do_look(input string tag, input logic [15:0] a, input logic [63:0] va);
    lk_valid = 1; lk_asid = a; lk_vaddr = va; tick(tag);
  endtask

  task automatic do_flush(input bit ua, input bit uv, input logic [15:0] a, input logic [63:0] va);
    fl_en = 1; fl_use_asid = ua; fl_use_addr = uv; fl_asid = a; fl_vaddr = va; tick("flush");
  endtask

  localparam logic [63:0] VA_A = 64'h0000_0040_0000_3000; // slot 3
  localparam logic [63:0] VA_B = 64'h0000_0000_4020_0000; // 2 MiB aligned

  initial begin
    clear_inputs();
    lk_asid = 0; lk_vaddr = 0; wr_index = 0; fl_asid = 0; fl_vaddr = 0;
    set_ent(0, 0, 0, 0, 0);
    model_reset();
    void'($urandom(32'd4242));
    rst = 1;
    repeat (3) tick("rst");
    rst = 0;

    // R1: empty after reset
    do_look("R1 after reset", 1, VA_A);
    chk("R1 miss after reset", 64'(rsp_hit), 64'd0);

    // R4 / R2: basic 4 KiB fill and hit
    do_fill(1, 0, 0, VA_A + 64'h5, 64'h0000_0000_8000_5123);
    do_look("R4 basic", 1, VA_A + 64'habc);
    chk("R4 paddr value", rsp_paddr, 64'h0000_0000_8000_5000);
    chk("R2 index value", 64'(rsp_index), 64'd3);

    // R3: ASID mismatch misses, global matches any
    do_look("R3 asid miss", 2, VA_A);
    chk("R3 other asid misses", 64'(rsp_hit), 64'd0);
    do_fill(7, 1, 0, 64'h0000_0000_0001_4000, 64'h9000);
    do_look("R3 global", 2, 64'h0000_0000_0001_4010);
    chk("R3 global hits", 64'(rsp_hit), 64'd1);

    // R5: superpage copies per 4 KiB region
    do_fill(1, 0, 1, VA_B + 64'h5000, 64'h0000_0001_2340_0000);
    do_look("R5 region filled", 1, VA_B + 64'h5008);
    chk("R5 mask level1", rsp_match_mask, ~64'h1f_ffff);
    do_look("R5 other region", 1, VA_B + 64'h6000);
    chk("R5 other region misses", 64'(rsp_hit), 64'd0);
    do_fill(1, 0, 1, VA_B + 64'h6000, 64'h0000_0001_2340_0000);
    do_look("R5 second copy", 1, VA_B + 64'h6000);
    chk("R5 second copy hits", 64'(rsp_hit), 64'd1);

    // R6: conflicting fill replaces
    do_fill(1, 0, 0, VA_A + 64'h40000, 64'h7000);
    do_look("R6 evicted", 1, VA_A);
    chk("R6 old entry gone", 64'(rsp_hit), 64'd0);
    do_look("R6 new", 1, VA_A + 64'h40000);

    // R7: write by index
    set_ent(3, 0, 0, 64'h0000_0000_0000_9000, 64'hab000);
    wr_en = 1; wr_index = 6'd9; tick("R7 write");
    do_look("R7 write hit", 3, 64'h0000_0000_0000_9000);
    chk("R7 written slot hits", 64'(rsp_hit), 64'd1);

    // R9: address-only flush removes the global entry too
    do_flush(0, 1, 0, 64'h0000_0000_0001_4fff);
    do_look("R9 flushed", 7, 64'h0000_0000_0001_4000);
    chk("R9 global removed", 64'(rsp_hit), 64'd0);

    // R10: ASID-only flush keeps global entries
    do_fill(2, 1, 0, 64'h0000_0000_0002_0000, 64'h1000);
    do_fill(1, 0, 0, 64'h0000_0000_0002_1000, 64'h2000);
    do_flush(1, 0, 2, 0);
    do_look("R10 global kept", 1, 64'h0000_0000_0002_0000);
    chk("R10 global survives", 64'(rsp_hit), 64'd1);
    do_flush(1, 0, 1, 0);
    do_look("R10 asid removed", 1, 64'h0000_0000_0002_1000);
    chk("R10 asid entry removed", 64'(rsp_hit), 64'd0);

    // R11: both filters
    do_fill(4, 0, 0, 64'h0000_0000_0003_0000, 64'h3000);
    do_fill(4, 0, 0, 64'h0000_0000_0003_1000, 64'h4000);
    do_flush(1, 1, 4, 64'h0000_0000_0003_0000);
    do_look("R11 target", 4, 64'h0000_0000_0003_0000);
    chk("R11 target removed", 64'(rsp_hit), 64'd0);
    do_look("R11 neighbour", 4, 64'h0000_0000_0003_1000);
    chk("R11 neighbour kept", 64'(rsp_hit), 64'd1);

    // R12: lookup with same-edge fill sees old contents
    set_ent(5, 0, 0, 64'h0000_0000_0004_0000, 64'h5000);
    fill_en = 1; lk_valid = 1; lk_asid = 5; lk_vaddr = 64'h0000_0000_0004_0000;
    tick("R12 same edge");
    chk("R12 old contents", 64'(rsp_hit), 64'd0);
    // R12: fill survives same-edge full flush
    set_ent(5, 0, 0, 64'h0000_0000_0005_0000, 64'h6000);
    fill_en = 1; fl_en = 1; tick("R12 flush+fill");
    do_look("R12 survivor", 5, 64'h0000_0000_0005_0000);
    chk("R12 fill survives flush", 64'(rsp_hit), 64'd1);
    do_look("R8 pre", 5, 64'h0000_0000_0004_0000);
    chk("R8 other slot flushed", 64'(rsp_hit), 64'd0);
    // R12: fill beats write
    set_ent(6, 0, 0, 64'h0000_0000_0006_0000, 64'h7000);
    fill_en = 1; wr_en = 1; wr_index = 6'd20; tick("R12 fill wins");
    do_look("R12 fill slot", 6, 64'h0000_0000_0006_0000);
    chk("R12 fill slot hit", 64'(rsp_hit), 64'd1);

    // R8: full flush
    do_flush(0, 0, 0, 0);
    do_look("R8 all gone", 6, 64'h0000_0000_0006_0000);
    chk("R8 all flushed", 64'(rsp_hit), 64'd0);

    // R1: reset clears populated buffer
    do_fill(1, 0, 0, VA_A, 64'h1000);
    rst = 1; tick("rst"); rst = 0;
    do_look("R1 reset clears", 1, VA_A);
    chk("R1 reset cleared", 64'(rsp_hit), 64'd0);

    // Random mix checked against the model (R3 hit rule throughout)
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom % 16);
      logic [63:0] va = (64'($urandom % 4) << 30) | (64'($urandom % 8) << 12) | 64'($urandom % 4096);
      logic [15:0] a = 16'(1 + $urandom % 3);
      if (op < 6) begin
        lk_valid = 1; lk_asid = a; lk_vaddr = va;
      end else if (op < 12) begin
        set_ent(a, ($urandom % 8) == 0, 2'($urandom % 3), va, {$urandom, $urandom});
        fill_en = 1;
        if (op >= 10) begin
          lk_valid = 1; lk_asid = 16'(1 + $urandom % 3);
          lk_vaddr = (64'($urandom % 4) << 30) | (64'($urandom % 8) << 12);
        end
      end else if (op < 14) begin
        set_ent(a, 0, 0, va, {$urandom, $urandom});
        wr_en = 1; wr_index = 6'($urandom % 8);
      end else if (op == 14) begin
        fl_en = 1; fl_use_asid = ($urandom % 4) != 0; fl_use_addr = ($urandom % 2) == 0;
        if (!fl_use_asid && !fl_use_addr) fl_use_addr = 1;
        fl_asid = a; fl_vaddr = va;
      end else begin
        lk_valid = 1; lk_asid = a; lk_vaddr = va;
        fl_en = ($urandom % 4) == 0; fl_use_asid = 1; fl_use_addr = 0; fl_asid = a;
      end
      tick("R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule